// File: doc/BRIEF.md
# Offset Calibration Sequencer

This block decides when a sense channel may measure its own input offset, and stores the result. A host sets a calibration request bit in an 8-bit mode register. The same register also holds a 3-bit code that selects the wake threshold. After that, the sequencer waits for a quiet period. The serial host line must sit low, and the analog front end must report that the sensed magnitude is below the wake threshold. Both conditions must hold for a short qualification interval first, and then for a long calibration interval.

When the long interval ends, the sequencer copies the measured offset into its offset register. It also clears the request bit itself, so the host learns that the run has finished by reading the mode register. If either quiet condition breaks before the end, the run stops and the tick timer starts again from zero. The request bit stays set, so a new attempt begins as soon as the channel is quiet again.

Time is counted in ticks from an external time base. The number of ticks in each interval is a parameter. The defaults assume a 1 s tick, which gives 10 s followed by one hour. The block also turns the threshold code into a threshold value in microvolts for the comparator that lies outside this block.

Top module: `ocal_seq`

## Requirements
- R1: After reset, the mode register reads 0x0E (threshold code 7, request bit clear), the offset register reads 0, and `qual_busy`, `cal_mode` and `cal_done` are low.
- R2: The threshold code sits in mode-register bits 3:1. `wake_thr_uv` equals 3840/code rounded to the nearest microvolt for codes 1 to 7 (3840, 1920, 1280, 960, 768, 640, 549). It is 0 for code 0.
- R3: A cycle with `cfg_we` high loads all 8 bits of `cfg_wdata` into the mode register. Without a write or a completion, the register holds its value.
- R4: Qualification starts one cycle after all four of these hold together: request bit 6 is set, the code is nonzero, `host_line` is low, and `below_thr` is high. `qual_busy` is then high. `cal_mode` rises only on the (QUAL_TICKS+1)-th tick counted in qualification.
- R5: While the threshold code is 0, no qualification or calibration starts, whatever the other inputs and ticks do.
- R6: If `host_line` goes high or `below_thr` goes low during qualification or calibration, the sequencer returns to idle on the next edge and the tick count restarts from zero. The request bit stays set.
- R7: On the HOUR_TICKS-th tick in calibration, the offset register loads `offset_meas` and bit 6 of the mode register is cleared on the same edge. `cal_done` is high for exactly one cycle, and `cal_mode` falls.
- R8: The offset register changes only at a completion. Changes on `offset_meas` at any other time, and aborted runs, leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle time-base pulse |
| host_line | input | 1 | Level of the serial host line (1 = high) |
| below_thr | input | 1 | Sensed magnitude is below the wake threshold |
| offset_meas | input | OFS_W | Current offset measurement |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 8 | Mode register write data |
| cfg_q | output | 8 | Mode register contents |
| offset_q | output | OFS_W | Stored offset |
| wake_thr_uv | output | 12 | Selected wake threshold in microvolts |
| qual_busy | output | 1 | Qualification interval in progress |
| cal_mode | output | 1 | Calibration interval in progress |
| cal_done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with QUAL_TICKS = 3 and HOUR_TICKS = 8. With these values, a full run is only a few dozen cycles. Each tick boundary can then be sampled: the third tick against the fourth in qualification, and the seventh against the eighth in calibration. Aborts after a partial count can be followed by a fresh attempt that must count the full length again. A scoreboard holds the offset expected at each completion, so the bench can detect a completion that happens when none is due.

// File: rtl/ocal_pkg.sv
`timescale 1ns/1ps
package ocal_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_QUAL = 2'd1,
    ST_CAL  = 2'd2
  } ocal_state_t;

  localparam int          REQ_BIT   = 6;
  localparam int          CODE_LSB  = 1;
  localparam int          CODE_W    = 3;
  localparam logic [7:0]  MODE_RST  = 8'h0E;
  localparam int          THR_FULL  = 3840;
  localparam int          THR_W     = 12;

  // Threshold in microvolts: full scale divided by the code, rounded to nearest.
  function automatic logic [THR_W-1:0] thr_from_code(input logic [CODE_W-1:0] code);
    int c;
    int v;
    c = int'(code);
    if (c == 0) v = 0;
    else        v = (2 * THR_FULL + c) / (2 * c);
    return THR_W'(v);
  endfunction

  // Quiet channel and armed request: the condition every phase depends on.
  function automatic logic quiet_ok(input logic [7:0] mode, input logic line,
                                    input logic below);
    return mode[REQ_BIT] && (mode[CODE_LSB +: CODE_W] != '0) && !line && below;
  endfunction

endpackage

// File: rtl/ocal_mode_reg.sv
`timescale 1ns/1ps
module ocal_mode_reg
  import ocal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  input  logic       hw_clr,
  output logic [7:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= MODE_RST;
    end else begin
      if (we) q <= wdata;
      if (hw_clr) q[REQ_BIT] <= 1'b0;
    end
  end

  // R7
  req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_clr |=> !q[REQ_BIT]);

  // R3
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && !hw_clr) |=> $stable(q));

endmodule

// File: rtl/ocal_tick_timer.sv
`timescale 1ns/1ps
module ocal_tick_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);

  logic [CNT_W-1:0] cnt;

  assign expire = tick && !clr && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clr || expire)    cnt <= '0;
    else if (tick)             cnt <= cnt + 1'b1;
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= limit);

  // R6
  clr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

endmodule

// File: rtl/ocal_ctrl.sv
`timescale 1ns/1ps
module ocal_ctrl
  import ocal_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cond_ok,
  input  logic        expire,
  output ocal_state_t state,
  output logic        timer_clr,
  output logic        in_qual,
  output logic        done_evt,
  output logic        abort_evt
);

  ocal_state_t nxt;
  logic        qual_expire;

  assign in_qual     = (state == ST_QUAL);
  assign timer_clr   = (state == ST_IDLE) || !cond_ok;
  assign abort_evt   = (state != ST_IDLE) && !cond_ok;
  assign qual_expire = in_qual && cond_ok && expire;
  assign done_evt    = (state == ST_CAL) && cond_ok && expire;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (cond_ok) nxt = ST_QUAL;
      ST_QUAL: if (!cond_ok) nxt = ST_IDLE;
               else if (qual_expire) nxt = ST_CAL;
      ST_CAL:  if (!cond_ok || done_evt) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  // R4
  no_skip_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |=> (state != ST_CAL));

  // R6
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (state == ST_IDLE));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (state == ST_IDLE));

endmodule

// File: rtl/ocal_seq.sv
`timescale 1ns/1ps
module ocal_seq
  import ocal_pkg::*;
#(
  parameter int OFS_W      = 8,
  parameter int QUAL_TICKS = 10,
  parameter int HOUR_TICKS = 3600
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             host_line,
  input  logic             below_thr,
  input  logic [OFS_W-1:0] offset_meas,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_q,
  output logic [OFS_W-1:0] offset_q,
  output logic [11:0]      wake_thr_uv,
  output logic             qual_busy,
  output logic             cal_mode,
  output logic             cal_done
);

  localparam int MAX_LIM = (QUAL_TICKS > HOUR_TICKS) ? QUAL_TICKS : HOUR_TICKS;
  localparam int CNT_W   = $clog2(MAX_LIM + 1);
  localparam logic [CNT_W-1:0] QUAL_LIM = CNT_W'(QUAL_TICKS);
  localparam logic [CNT_W-1:0] HOUR_LIM = CNT_W'(HOUR_TICKS - 1);

  // Named internal events for the checks
  logic        cond_ok;
  logic        expire;
  logic        timer_clr;
  logic        in_qual;
  logic        done_evt;
  logic        abort_evt;
  ocal_state_t state;
  logic [CNT_W-1:0] limit;

  assign cond_ok     = quiet_ok(cfg_q, host_line, below_thr);
  assign limit       = in_qual ? QUAL_LIM : HOUR_LIM;
  assign wake_thr_uv = thr_from_code(cfg_q[CODE_LSB +: CODE_W]);
  assign qual_busy   = (state == ST_QUAL);
  assign cal_mode    = (state == ST_CAL);

  ocal_mode_reg u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .hw_clr (done_evt),
    .q      (cfg_q)
  );

  ocal_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (timer_clr),
    .tick   (tick),
    .limit  (limit),
    .expire (expire)
  );

  ocal_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cond_ok   (cond_ok),
    .expire    (expire),
    .state     (state),
    .timer_clr (timer_clr),
    .in_qual   (in_qual),
    .done_evt  (done_evt),
    .abort_evt (abort_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offset_q <= '0;
      cal_done <= 1'b0;
    end else begin
      cal_done <= done_evt;
      if (done_evt) offset_q <= offset_meas;
    end
  end

  // R7
  ofs_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (offset_q == $past(offset_meas)));

  // R8
  ofs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_evt |=> $stable(offset_q));

  // R5
  code_zero_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[CODE_LSB +: CODE_W] == '0) |-> !done_evt);

  // R6
  abort_keeps_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_evt && !cfg_we) |=> cfg_q[REQ_BIT]);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> (!cal_mode && !cfg_q[REQ_BIT]));

endmodule

// File: tb/ocal_seq_tb.sv
`timescale 1ns/1ps
module ocal_seq_tb_top;

  localparam int QT = 3;
  localparam int HT = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       host_line = 1'b1;
  logic       below_thr = 1'b0;
  logic [7:0] offset_meas = 8'h00;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_q;
  logic [7:0] offset_q;
  logic [11:0] wake_thr_uv;
  logic       qual_busy;
  logic       cal_mode;
  logic       cal_done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  int exp_q[$];

  always #10 clk = ~clk;

  ocal_seq #(.OFS_W(8), .QUAL_TICKS(QT), .HOUR_TICKS(HT)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .host_line(host_line),
    .below_thr(below_thr), .offset_meas(offset_meas), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_q(cfg_q), .offset_q(offset_q),
    .wake_thr_uv(wake_thr_uv), .qual_busy(qual_busy), .cal_mode(cal_mode),
    .cal_done(cal_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  function automatic int thr_ref(input int code);
    case (code)
      1: return 3840;  2: return 1920;  3: return 1280;  4: return 960;
      5: return 768;   6: return 640;   7: return 549;   default: return 0;
    endcase
  endfunction

  // Monitor: each completion pulse consumes one expected offset.
  always @(negedge clk) begin
    if (rst_n && cal_done && !finished) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7", "unexpected cal_done", 1, 0);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(offset_q == 8'(e), "R7", "offset_q at done", int'(offset_q), e);
        chk(cfg_q[6] == 1'b0, "R7", "request bit at done", int'(cfg_q[6]), 0);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    chk(cfg_q == 8'h0E, "R1", "cfg_q", int'(cfg_q), 'h0E);
    chk(offset_q == 8'h00, "R1", "offset_q", int'(offset_q), 0);
    chk(!qual_busy && !cal_mode && !cal_done, "R1", "status", int'({qual_busy, cal_mode, cal_done}), 0);
    chk(wake_thr_uv == 12'd549, "R2", "default threshold", int'(wake_thr_uv), 549);

    // R2 / R3 threshold decode across every code, request bit clear
    for (int c = 0; c < 8; c++) begin
      write_cfg(8'(c << 1) | 8'h80);
      chk(cfg_q == (8'(c << 1) | 8'h80), "R3", "cfg load", int'(cfg_q), int'(8'(c << 1) | 8'h80));
      chk(int'(wake_thr_uv) == thr_ref(c), "R2", "threshold", int'(wake_thr_uv), thr_ref(c));
    end

    // R8 offset input moves while idle
    offset_meas = 8'h3C;
    cyc(3);
    chk(offset_q == 8'h00, "R8", "offset idle hold", int'(offset_q), 0);

    // R5 code 0 blocks entry even with request set and quiet channel
    host_line = 1'b0; below_thr = 1'b1;
    write_cfg(8'h40);
    for (int i = 0; i < QT + HT + 3; i++) pulse_tick();
    chk(!qual_busy && !cal_mode, "R5", "no entry code 0", int'({qual_busy, cal_mode}), 0);
    chk(cfg_q[6] == 1'b1, "R5", "request stays", int'(cfg_q[6]), 1);

    // R4 request clear blocks entry
    write_cfg(8'h0E);
    cyc(2);
    chk(!qual_busy, "R4", "no entry without request", int'(qual_busy), 0);

    // R4 / R7 full run with offset 0x65
    offset_meas = 8'h65;
    write_cfg(8'h4E);
    cyc(1);
    chk(qual_busy && !cal_mode, "R4", "qualification starts", int'({qual_busy, cal_mode}), 2);
    for (int i = 0; i < QT; i++) pulse_tick();
    chk(qual_busy && !cal_mode, "R4", "still qualifying after QT ticks", int'({qual_busy, cal_mode}), 2);
    pulse_tick();
    chk(cal_mode && !qual_busy, "R4", "calibration entered", int'({qual_busy, cal_mode}), 1);
    for (int i = 0; i < HT - 1; i++) pulse_tick();
    chk(cal_mode && cfg_q[6], "R7", "before last tick", int'({cal_mode, cfg_q[6]}), 3);
    exp_q.push_back('h65);
    pulse_tick();
    chk(!cal_mode && cal_done, "R7", "completion", int'({cal_mode, cal_done}), 1);
    chk(cfg_q == 8'h0E, "R7", "mode after done", int'(cfg_q), 'h0E);
    cyc(1);
    chk(!cal_done, "R7", "done is one cycle", int'(cal_done), 0);
    cyc(2);
    chk(!qual_busy, "R7", "no restart after done", int'(qual_busy), 0);

    // R6 abort in qualification by host line, then full restart
    offset_meas = 8'hA3;
    write_cfg(8'h46);
    cyc(1);
    pulse_tick(); pulse_tick();
    @(negedge clk); host_line = 1'b1;
    @(negedge clk);
    chk(!qual_busy && !cal_mode, "R6", "abort on line high", int'({qual_busy, cal_mode}), 0);
    chk(cfg_q[6] == 1'b1, "R6", "request kept", int'(cfg_q[6]), 1);
    host_line = 1'b0;
    cyc(1);
    chk(qual_busy, "R6", "requalify", int'(qual_busy), 1);
    for (int i = 0; i < QT; i++) pulse_tick();
    chk(!cal_mode, "R6", "count restarted", int'(cal_mode), 0);
    pulse_tick();
    chk(cal_mode, "R6", "cal after full count", int'(cal_mode), 1);

    // R6 / R8 abort in calibration by signal rising above threshold
    for (int i = 0; i < HT - 2; i++) pulse_tick();
    @(negedge clk); below_thr = 1'b0;
    @(negedge clk);
    chk(!cal_mode && !qual_busy, "R6", "abort in cal", int'({qual_busy, cal_mode}), 0);
    chk(offset_q == 8'h65, "R8", "offset after abort", int'(offset_q), 'h65);
    chk(cfg_q[6] == 1'b1, "R6", "request kept in cal abort", int'(cfg_q[6]), 1);
    below_thr = 1'b1;
    cyc(1);
    for (int i = 0; i < QT + 1; i++) pulse_tick();
    chk(cal_mode, "R4", "re-entered cal", int'(cal_mode), 1);
    for (int i = 0; i < HT - 1; i++) pulse_tick();
    chk(cal_mode, "R6", "cal count restarted", int'(cal_mode), 1);
    offset_meas = 8'h5A;
    exp_q.push_back('h5A);
    pulse_tick();
    chk(cfg_q == 8'h06, "R7", "mode after second done", int'(cfg_q), 'h06);
    cyc(3);
    chk(offset_q == 8'h5A, "R8", "offset kept", int'(offset_q), 'h5A);
    chk(exp_q.size() == 0, "R7", "all completions seen", exp_q.size(), 0);
    finish_run();
  end

endmodule